// File: doc/BRIEF.md
# Dual Event Counter Performance Monitor

This block counts hardware events for profiling. It has two 32-bit counters. Each counter takes one strobe from a bank of event inputs, and a per-counter select field in a single shared control word picks that strobe. Three context-enable bits sit in the same control word: one for user, one for supervisor and one for hypervisor. A counter advances only while the processor's current privilege context has its enable bit set. Because the enables are shared, the two counters always start and stop together. The only way to halt counting is to clear all three enables.

Software sees two words through a small read/write port. One word is the control word. The other word packs both counters into 64 bits, so a single access reads or loads both of them. When a counter rolls over from all ones to zero, it sets its own sticky overflow flag. Separate flags are needed because an unused counter keeps running and can also overflow. The interrupt request is raised while either flag is set. Software clears a flag by writing a one to it.

Top module: `dual_evt_pmu`

## Requirements
- R1: After reset, both counters, both select fields, all three context enables and both overflow flags are zero, and `irq_o` is low.
- R2: In a cycle with no counter-word write, counter k (k = 0, 1) grows by exactly one when two conditions hold: the strobe `evt_i[sel_k]` is high, and the enable bit for the current context is set. The context encoding on `ctx_i` is 0 user, 1 supervisor, 2 hypervisor and 3 idle. Idle never counts.
- R3: The three context enables act on both counters together. With all three enables clear, neither counter moves under any strobe or context.
- R4: The two select fields are independent. A select value at or above `NUM_EVT` (40 by default) counts nothing.
- R5: Address 1 is the counter word. Counter 0 is in bits [31:0] and counter 1 is in bits [63:32]. One write loads both counters, and the loaded values are readable on the next cycle.
- R6: A counter-word write takes precedence over a same-cycle increment. A write never sets an overflow flag, even when it replaces an all-ones counter.
- R7: An increment that takes a counter from 0xFFFFFFFF to 0 sets that counter's sticky flag. The flag for counter 0 is control bit 24 and the flag for counter 1 is control bit 25.
- R8: Writing the control word clears each flag whose bit is written as 1 and leaves a flag unchanged when its bit is written as 0. If a wrap and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: `irq_o` is high exactly while at least one overflow flag is set.
- R10: Address 0 is the control word. Select 0 is in bits [5:0] and select 1 is in bits [13:8]. The user, supervisor and hypervisor enables are in bits 16, 17 and 18. The flags are in bits 24 and 25. All other bits read as zero. New settings take effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event strobes, one per event number |
| ctx_i | input | 2 | Current privilege context (0 user, 1 supervisor, 2 hypervisor, 3 idle) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control word, 1 counter word |
| reg_wdata_i | input | 2*CNT_W | Write data |
| reg_rdata_o | output | 2*CNT_W | Read data for the addressed word, combinational |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The sharp corner is a counter wrapping in the same cycle that software acts on the state the wrap touches. Two cases matter. The first is a control write that clears the flag the wrap is setting. The second is a counter-word write that lands while the counter sits at all ones with its event strobe active. The bench sets up both cases on purpose: it preloads a counter to 0xFFFFFFFF and then issues the write in the very cycle the strobe fires. A behavioural model updated on every clock decides the outcome. The set must win over the clear, and the load must win over both the increment and the flag. The readback and `irq_o` are compared against that model on every cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   typedef enum logic [1:0] {
      CTX_USER  = 2'd0,
      CTX_SUPER = 2'd1,
      CTX_HYPER = 2'd2,
      CTX_IDLE  = 2'd3
   } pmu_ctx_e;

   localparam int unsigned NUM_CTX  = 3;
   localparam int unsigned SEL0_LSB = 0;
   localparam int unsigned SEL1_LSB = 8;
   localparam int unsigned SEL_SPAN = 8;
   localparam int unsigned EN_LSB   = 16;
   localparam int unsigned OVF_LSB  = 24;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_CNT  = 1'b1;
endpackage

// File: rtl/pmu_evt_mux.sv
module pmu_evt_mux #(
   parameter int unsigned NUM_EVT = 40,
   parameter int unsigned SEL_W   = 6
) (
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               hit_o
);
   localparam int unsigned SPACE = 2 ** SEL_W;

   generate
      if (NUM_EVT > SPACE) begin : g_bad
         $error("pmu_evt_mux: NUM_EVT exceeds select space");
      end
      if (NUM_EVT == SPACE) begin : g_full
         assign hit_o = evt_i[sel_i];
      end else begin : g_padded
         logic [SPACE-1:0] padded;
         assign padded = {{(SPACE - NUM_EVT){1'b0}}, evt_i};
         assign hit_o  = padded[sel_i];
      end
   endgenerate
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] q_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld_i) begin
         q <= ld_val_i;
      end else if (inc_i) begin
         q <= q + CNT_W'(1);
      end
   end

   assign wrap_o = inc_i && !ld_i && (&q);
   assign q_o    = q;
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl #(
   parameter int unsigned SEL_W = 6,
   parameter int unsigned REG_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [1:0]         wrap_i,
   output logic [SEL_W-1:0]   sel0_o,
   output logic [SEL_W-1:0]   sel1_o,
   output logic [pmu_pkg::NUM_CTX-1:0] en_o,
   output logic [1:0]         flag_o,
   output logic [REG_W-1:0]   word_o
);
   import pmu_pkg::*;

   logic [SEL_W-1:0]   sel0_q, sel1_q;
   logic [NUM_CTX-1:0] en_q;
   logic [1:0]         flag_q;
   logic [1:0]         clr;

   generate
      if (SEL_W > SEL_SPAN) begin : g_bad_sel
         $error("pmu_ctrl: select field wider than its slot");
      end
      if (REG_W < OVF_LSB + 2) begin : g_bad_w
         $error("pmu_ctrl: register too narrow for the flag bits");
      end
   endgenerate

   assign clr = we_i ? wdata_i[OVF_LSB +: 2] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel0_q <= '0;
         sel1_q <= '0;
         en_q   <= '0;
      end else if (we_i) begin
         sel0_q <= wdata_i[SEL0_LSB +: SEL_W];
         sel1_q <= wdata_i[SEL1_LSB +: SEL_W];
         en_q   <= wdata_i[EN_LSB +: NUM_CTX];
      end
   end

   // Set has priority over a write-one clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr) | wrap_i;
      end
   end

   always_comb begin
      word_o = '0;
      word_o[SEL0_LSB +: SEL_W]  = sel0_q;
      word_o[SEL1_LSB +: SEL_W]  = sel1_q;
      word_o[EN_LSB +: NUM_CTX]  = en_q;
      word_o[OVF_LSB +: 2]       = flag_q;
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   assign sel0_o = sel0_q;
   assign sel1_o = sel1_q;
   assign en_o   = en_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/dual_evt_pmu.sv
module dual_evt_pmu #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned SEL_W   = 6,
   parameter int unsigned NUM_EVT = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_EVT-1:0]   evt_i,
   input  logic [1:0]           ctx_i,
   input  logic                 reg_we_i,
   input  logic                 reg_addr_i,
   input  logic [2*CNT_W-1:0]   reg_wdata_i,
   output logic [2*CNT_W-1:0]   reg_rdata_o,
   output logic                 irq_o
);
   import pmu_pkg::*;

   localparam int unsigned REG_W = 2 * CNT_W;
   localparam int unsigned N_CNT = 2;

   logic               ctrl_we, cnt_ld;
   logic [SEL_W-1:0]   sel [N_CNT];
   logic [NUM_CTX-1:0] en;
   logic [1:0]         flag;
   logic [REG_W-1:0]   ctrl_word;
   logic               ctx_on;
   logic [N_CNT-1:0]   hit, wrap;
   logic [CNT_W-1:0]   cnt [N_CNT];

   assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_CTRL);
   assign cnt_ld  = reg_we_i && (reg_addr_i == ADDR_CNT);

   pmu_ctrl #(.SEL_W(SEL_W), .REG_W(REG_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctrl_we),
      .wdata_i (reg_wdata_i),
      .wrap_i  (wrap),
      .sel0_o  (sel[0]),
      .sel1_o  (sel[1]),
      .en_o    (en),
      .flag_o  (flag),
      .word_o  (ctrl_word)
   );

   always_comb begin
      unique case (pmu_ctx_e'(ctx_i))
         CTX_USER:  ctx_on = en[0];
         CTX_SUPER: ctx_on = en[1];
         CTX_HYPER: ctx_on = en[2];
         default:   ctx_on = 1'b0;
      endcase
   end

   generate
      for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
         pmu_evt_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
            .evt_i (evt_i),
            .sel_i (sel[k]),
            .hit_o (hit[k])
         );
         pmu_counter #(.CNT_W(CNT_W)) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (cnt_ld),
            .ld_val_i (reg_wdata_i[k*CNT_W +: CNT_W]),
            .inc_i    (hit[k] && ctx_on),
            .q_o      (cnt[k]),
            .wrap_o   (wrap[k])
         );
      end
   endgenerate

   assign reg_rdata_o = (reg_addr_i == ADDR_CNT) ? {cnt[1], cnt[0]} : ctrl_word;
   assign irq_o       = |flag;
endmodule

// File: rtl/dual_evt_pmu_chk.sv
module dual_evt_pmu_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cnt_ld,
   input logic               ctrl_we,
   input logic [2*CNT_W-1:0] wdata,
   input logic [CNT_W-1:0]   cnt0,
   input logic [CNT_W-1:0]   cnt1,
   input logic               hit0,
   input logic               hit1,
   input logic               ctx_on,
   input logic [1:0]         flag
);
   a_r2_step0: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_ld |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1)));
   a_r2_step1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_ld |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + CNT_W'(1)));
   a_r3_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_ld && !ctx_on) |=> ($stable(cnt0) && $stable(cnt1)));
   a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt0 == $past(wdata[CNT_W-1:0]) && cnt1 == $past(wdata[2*CNT_W-1:CNT_W])));
   a_r7_wrap_flag0: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_ld && ctx_on && hit0 && (&cnt0)) |=> flag[0]);
   a_r7_wrap_flag1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_ld && ctx_on && hit1 && (&cnt1)) |=> flag[1]);
   a_r8_sticky0: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[0] && !(ctrl_we && wdata[24])) |=> flag[0]);
   a_r8_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[1] && !(ctrl_we && wdata[25])) |=> flag[1]);
endmodule

bind dual_evt_pmu dual_evt_pmu_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt_ld  (cnt_ld),
   .ctrl_we (ctrl_we),
   .wdata   (reg_wdata_i),
   .cnt0    (cnt[0]),
   .cnt1    (cnt[1]),
   .hit0    (hit[0]),
   .hit1    (hit[1]),
   .ctx_on  (ctx_on),
   .flag    (flag)
);

// File: tb/tb_dual_evt_pmu.sv
`timescale 1ns/1ps
module tb_dual_evt_pmu;
   localparam int NE = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt = '0;
   logic [1:0]    ctx = 2'd3;
   logic          we = 1'b0;
   logic          addr = 1'b0;
   logic [63:0]   wd = '0;
   logic [63:0]   rdata;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dual_evt_pmu dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctx_i(ctx),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   // behavioural reference model
   longint unsigned m_cnt [2];
   int              m_sel [2];
   bit              m_en  [3];
   bit              m_flag[2];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_cnt[k] = 0; m_sel[k] = 0; m_flag[k] = 0;
         end
         for (int c = 0; c < 3; c++) m_en[c] = 0;
      end else begin
         bit on;
         bit wrapped [2];
         on = (ctx != 2'd3) && m_en[ctx];
         for (int k = 0; k < 2; k++) begin
            bit inc;
            inc = on && (m_sel[k] < NE) && evt[m_sel[k]];
            wrapped[k] = 0;
            if (we && addr) begin
               m_cnt[k] = (k == 0) ? wd[31:0] : wd[63:32];
            end else if (inc) begin
               if (m_cnt[k] == 64'hFFFF_FFFF) begin
                  m_cnt[k] = 0; wrapped[k] = 1;
               end else begin
                  m_cnt[k] = m_cnt[k] + 1;
               end
            end
         end
         if (we && !addr) begin
            m_sel[0] = int'(wd[5:0]);
            m_sel[1] = int'(wd[13:8]);
            for (int c = 0; c < 3; c++) m_en[c] = wd[16+c];
            for (int k = 0; k < 2; k++) if (wd[24+k]) m_flag[k] = 0;
         end
         for (int k = 0; k < 2; k++) if (wrapped[k]) m_flag[k] = 1;
      end
   end

   function automatic logic [63:0] model_word(logic a);
      logic [63:0] r = '0;
      if (a) begin
         r = {m_cnt[1][31:0], m_cnt[0][31:0]};
      end else begin
         r[5:0]  = 6'(m_sel[0]);
         r[13:8] = 6'(m_sel[1]);
         for (int c = 0; c < 3; c++) r[16+c] = m_en[c];
         r[24] = m_flag[0];
         r[25] = m_flag[1];
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one cycle, compare against the model every cycle
   task automatic cyc(input logic w, input logic a, input logic [63:0] d,
                      input logic [1:0] cx, input logic [NE-1:0] ev);
      we = w; addr = a; wd = d; ctx = cx; evt = ev;
      #1;
      check(rdata === model_word(a), "R5/R10 model readback", rdata, model_word(a));
      check(irq === (m_flag[0] | m_flag[1]), "R9 model irq", 64'(irq), 64'(m_flag[0] | m_flag[1]));
      @(negedge clk);
   endtask

   task automatic peek(input logic a, input logic [63:0] exp, input string tag);
      we = 1'b0; addr = a; evt = '0; ctx = 2'd3;
      #1;
      check(rdata === exp, tag, rdata, exp);
      @(negedge clk);
   endtask

   task automatic irq_is(input logic exp, input string tag);
      #1;
      check(irq === exp, tag, 64'(irq), 64'(exp));
   endtask

   localparam logic [NE-1:0] ALL = '1;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek(0, 64'h0, "R1 ctrl after reset");
      peek(1, 64'h0, "R1 counters after reset");
      irq_is(1'b0, "R1 irq after reset");
      // R10 layout: sel0=3 sel1=5 user enable
      cyc(1, 0, 64'h0001_0503, 2'd3, '0);
      peek(0, 64'h0001_0503, "R10 ctrl readback");
      // R2 independent counting in user context
      cyc(0, 1, 0, 2'd0, NE'(1) << 3);
      cyc(0, 1, 0, 2'd0, NE'(1) << 3);
      cyc(0, 1, 0, 2'd0, NE'(1) << 5);
      cyc(0, 1, 0, 2'd0, (NE'(1) << 3) | (NE'(1) << 5));
      peek(1, {32'd2, 32'd3}, "R2 counts user ctx");
      // R3 disabled context, R2 idle context
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 2'd1, ALL);
      for (int i = 0; i < 2; i++) cyc(0, 1, 0, 2'd3, ALL);
      peek(1, {32'd2, 32'd3}, "R3 no count in disabled/idle ctx");
      // R3 supervisor+hypervisor enables act on both
      cyc(1, 0, 64'h0006_0503, 2'd3, '0);
      cyc(0, 1, 0, 2'd1, ALL);
      cyc(0, 1, 0, 2'd2, ALL);
      cyc(0, 1, 0, 2'd0, ALL);
      peek(1, {32'd4, 32'd5}, "R3 shared enables");
      // R3 all enables clear stops everything
      cyc(1, 0, 64'h0000_0503, 2'd3, '0);
      for (int c = 0; c < 4; c++) cyc(0, 1, 0, 2'(c), ALL);
      peek(1, {32'd4, 32'd5}, "R3 all enables clear");
      // R4 out-of-range select counts nothing
      cyc(1, 0, 64'h0007_272D, 2'd3, '0);
      cyc(0, 1, 0, 2'd0, ALL);
      cyc(0, 1, 0, 2'd0, ALL);
      peek(1, {32'd6, 32'd5}, "R4 unused select");
      // R5/R6 packed load wins over active events
      cyc(1, 1, {32'h1234_5678, 32'hFFFF_FFFE}, 2'd0, ALL);
      peek(1, {32'h1234_5678, 32'hFFFF_FFFE}, "R5 packed load");
      // R7 wrap sets flag 0
      cyc(1, 0, 64'h0001_0100, 2'd3, '0);
      cyc(0, 1, 0, 2'd0, NE'(1));
      cyc(0, 1, 0, 2'd0, NE'(1));
      peek(1, {32'h1234_5678, 32'h0}, "R7 wrap to zero");
      peek(0, 64'h0101_0100, "R7 flag0 set");
      irq_is(1'b1, "R9 irq with flag");
      // R8 write-zero keeps, write-one clears
      cyc(1, 0, 64'h0001_0100, 2'd3, '0);
      peek(0, 64'h0101_0100, "R8 zero leaves flag");
      cyc(1, 0, 64'h0101_0100, 2'd3, '0);
      peek(0, 64'h0001_0100, "R8 one clears flag");
      irq_is(1'b0, "R9 irq drops");
      // R8 wrap and clear in the same cycle: set wins
      cyc(1, 1, {32'hFFFF_FFFF, 32'h0}, 2'd3, '0);
      cyc(1, 0, 64'h0201_0100, 2'd0, NE'(2));
      peek(0, 64'h0201_0100, "R8 set beats clear");
      irq_is(1'b1, "R9 irq flag1");
      cyc(1, 0, 64'h0201_0100, 2'd3, '0);
      peek(0, 64'h0001_0100, "R8 flag1 cleared");
      // R6 load replaces all-ones counters with events active: no flag
      cyc(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, '0);
      cyc(1, 1, {32'd5, 32'd7}, 2'd0, NE'(3));
      peek(1, {32'd5, 32'd7}, "R6 load beats increment");
      peek(0, 64'h0001_0100, "R6 no flag from load");
      irq_is(1'b0, "R6 irq stays low");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule